// File: doc/BRIEF.md
# EEPROM Status and Protection Guard

This block keeps the status register of a serial EEPROM and makes every write-protection decision for it. The command decoder sends it one-cycle strobes for write-enable, write-disable and status-write. With the status-write strobe it also sends the data byte and a flag. The flag says whether chip select rose exactly on the byte boundary after the eighth data bit. The array write sequencer reports its busy level and a completion pulse. It reads back two things: whether the address it is about to program lies in a locked region, and whether a write may start at all.

A status write that passes every gate starts a self-timed cycle of `SR_CYCLES` clocks. The protection bits in force do not change while that cycle runs. The staged values are applied only when it ends, and the write-enable latch is cleared in the same edge. A locking bit combines with an active-low write-protect pin to give a hardware lock on the protection bits. Only raising the pin releases that lock. The non-volatile bits are flops whose reset value is the `NV_INIT` parameter. The status byte for reads is assembled combinationally from the current state.

Top module: `sr_guard`

## Requirements
- R1: The status byte is {lock bit (bit 7), three zeros (bits 6..4), region code high (bit 3), region code low (bit 2), enable latch (bit 1), busy (bit 0)}. After reset it reads {NV_INIT[2], 000, NV_INIT[1:0], 0, 0}, with NV_INIT = 0 by default.
- R2: A write-enable strobe sets the enable latch, visible on the next cycle. A write-disable strobe clears it. When both arrive in the same cycle, the latch is cleared.
- R3: A completion pulse from the array write sequencer clears the enable latch on the next cycle.
- R4: A status-write strobe is accepted only when all of these hold: the enable latch is 1, the boundary flag is 1, busy is 0 and the hardware lock is off. A rejected strobe leaves the status byte unchanged.
- R5: An accepted status write changes only the lock bit and the region code, taken from data bits 7, 3 and 2. Data bits 6..4, 1 and 0 are ignored.
- R6: Busy reads 1 for exactly SR_CYCLES cycles after the accepting edge. Through those cycles the old lock bit and region code stay in force. At the end the new values appear, busy returns to 0 and the enable latch is 0.
- R7: `hw_lock` is 1 exactly when the lock bit is 1 and `wp_n` is 0, whichever of the two became true first. Driving `wp_n` high releases it.
- R8: While the lock bit is 0, `wp_n` has no effect on whether a status write is accepted.
- R9: The region code selects the locked range of a 2^ADDR_W array: 00 none, 01 the top quarter, 10 the top half, 11 everything. `addr_locked` judges the page base address of `chk_addr`.
- R10: `arr_busy` drives the busy bit. `wr_permit` is 1 exactly when the enable latch is 1, busy is 0 and `addr_locked` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wren_stb | input | 1 | Write-enable command strobe |
| wrdi_stb | input | 1 | Write-disable command strobe |
| wrsr_stb | input | 1 | Status-write frame ended strobe |
| wrsr_aligned | input | 1 | Chip select rose right after the eighth data bit |
| wrsr_byte | input | 8 | Status-write data byte |
| arr_busy | input | 1 | Array write cycle running |
| arr_done | input | 1 | Array write cycle completed (pulse) |
| wp_n | input | 1 | Write-protect pin, active low |
| chk_addr | input | ADDR_W | Address the sequencer wants to program |
| status_byte | output | 8 | Status byte for reads |
| hw_lock | output | 1 | Hardware lock on protection bits active |
| addr_locked | output | 1 | Page of chk_addr lies in the locked region |
| wr_permit | output | 1 | Array write may start at chk_addr |

## Verification
The enable latch responds one clock after its strobe. The bench drives every strobe just after a falling edge and reads the status byte at the next falling edge. An accepted status write shows busy from that same falling edge onward. The bench counts SR_CYCLES-1 further falling edges and confirms that busy and the old protection bits still hold, then checks one edge later that the new bits have landed. The lock, region and permit outputs are combinational. They are sampled one time step after the address or pin changes, with no clock in between.

// File: rtl/sr_guard.sv
module sr_guard #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5,
  parameter int SR_CYCLES = 8,
  parameter logic [2:0] NV_INIT = 3'b000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_stb,
  input  logic              wrdi_stb,
  input  logic              wrsr_stb,
  input  logic              wrsr_aligned,
  input  logic [7:0]        wrsr_byte,
  input  logic              arr_busy,
  input  logic              arr_done,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [7:0]        status_byte,
  output logic              hw_lock,
  output logic              addr_locked,
  output logic              wr_permit
);
  localparam int CW = $clog2(SR_CYCLES + 1);

  logic          lock_bit;
  logic [1:0]    region;
  logic          wel;
  logic          sr_busy;
  logic [CW-1:0] cnt;
  logic [2:0]    staged;
  logic          wip, sr_done, wrsr_go;
  logic [ADDR_W-1:0] page_base;
  logic [1:0]    top2;

  assign wip         = sr_busy | arr_busy;
  assign hw_lock     = lock_bit & ~wp_n;
  assign sr_done     = sr_busy && (cnt == '0);
  assign wrsr_go     = wrsr_stb & wrsr_aligned & wel & ~wip & ~hw_lock;
  assign status_byte = {lock_bit, 3'b000, region, wel, wip};

  assign page_base = {chk_addr[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
  assign top2      = page_base[ADDR_W-1 -: 2];

  always_comb begin
    case (region)
      2'b00:   addr_locked = 1'b0;
      2'b01:   addr_locked = (top2 == 2'b11);
      2'b10:   addr_locked = top2[1];
      default: addr_locked = 1'b1;
    endcase
  end

  assign wr_permit = wel & ~wip & ~addr_locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                wel <= 1'b0;
    else if (wrdi_stb || arr_done || sr_done)  wel <= 1'b0;
    else if (wren_stb)                         wel <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_busy  <= 1'b0;
      cnt      <= '0;
      staged   <= NV_INIT;
      lock_bit <= NV_INIT[2];
      region   <= NV_INIT[1:0];
    end else if (wrsr_go) begin
      sr_busy <= 1'b1;
      cnt     <= CW'(SR_CYCLES - 1);
      staged  <= {wrsr_byte[7], wrsr_byte[3:2]};
    end else if (sr_busy) begin
      if (cnt == '0) begin
        sr_busy  <= 1'b0;
        lock_bit <= staged[2];
        region   <= staged[1:0];
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  a_r2_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wrdi_stb |=> !status_byte[1]);
  a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arr_done |=> !status_byte[1]);
  a_r4_no_wel_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_stb && !wel && !sr_busy) |=> !sr_busy);
  a_r6_prot_moves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({lock_bit, region}) |-> ($past(sr_busy) && !sr_busy));
  a_r6_end_wel_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_busy) |-> !status_byte[1]);
  a_r7_hw_lock_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_stb && hw_lock && !sr_busy) |=> !sr_busy);
endmodule

// File: tb/sr_guard_test.sv
module sr_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 13;
  localparam int PAGE_W = 5;
  localparam int SR_CYCLES = 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 0, rst_n = 0;
  logic wren_stb = 0, wrdi_stb = 0, wrsr_stb = 0, wrsr_aligned = 0;
  logic [7:0] wrsr_byte = 0;
  logic arr_busy = 0, arr_done = 0, wp_n = 1;
  logic [ADDR_W-1:0] chk_addr = 0;
  logic [7:0] status_byte;
  logic hw_lock, addr_locked, wr_permit;
  int checks = 0, errors = 0;

  sr_guard #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SR_CYCLES(SR_CYCLES)) uut (
    .clk(clk), .rst_n(rst_n), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
    .wrsr_stb(wrsr_stb), .wrsr_aligned(wrsr_aligned), .wrsr_byte(wrsr_byte),
    .arr_busy(arr_busy), .arr_done(arr_done), .wp_n(wp_n), .chk_addr(chk_addr),
    .status_byte(status_byte), .hw_lock(hw_lock), .addr_locked(addr_locked),
    .wr_permit(wr_permit));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wren();
    wren_stb = 1; @(negedge clk); wren_stb = 0;
  endtask

  task automatic wrsr(input logic [7:0] d, input logic al);
    wrsr_stb = 1; wrsr_byte = d; wrsr_aligned = al;
    @(negedge clk);
    wrsr_stb = 0; wrsr_aligned = 0;
  endtask

  task automatic set_status(input logic [7:0] d);
    wren(); wrsr(d, 1); repeat (SR_CYCLES) @(negedge clk);
  endtask

  function automatic bit exp_lock(input int bp, input int a);
    int base;
    base = (a >> PAGE_W) << PAGE_W;
    return (bp == 3) || (bp == 2 && base >= DEPTH/2) || (bp == 1 && base >= DEPTH*3/4);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset status", status_byte, 8'h00);
    chk("R7 reset hw_lock", hw_lock, 0);

    wren(); chk("R2 wren sets", status_byte, 8'h02);
    wrdi_stb = 1; @(negedge clk); wrdi_stb = 0;
    chk("R2 wrdi clears", status_byte, 8'h00);
    wren(); wren_stb = 1; wrdi_stb = 1; @(negedge clk); wren_stb = 0; wrdi_stb = 0;
    chk("R2 both clears", status_byte, 8'h00);

    wrsr(8'h8C, 1); chk("R4 no wel rejected", status_byte, 8'h00);
    wren(); wrsr(8'h8C, 0); chk("R4 misaligned rejected", status_byte, 8'h02);
    arr_busy = 1; #1;
    chk("R10 arr_busy shows wip", status_byte, 8'h03);
    wrsr(8'h8C, 1); arr_busy = 0; #1;
    chk("R4 busy rejected", status_byte, 8'h02);
    arr_done = 1; @(negedge clk); arr_done = 0;
    chk("R3 done clears wel", status_byte, 8'h00);

    set_status(8'h73);
    chk("R5 ignored bits", status_byte, 8'h00);

    wren(); wrsr(8'h8C, 1);
    chk("R6 busy start old bits", status_byte, 8'h03);
    repeat (SR_CYCLES-1) @(negedge clk);
    chk("R6 last busy cycle", status_byte, 8'h03);
    @(negedge clk);
    chk("R6 new bits applied", status_byte, 8'h8C);

    wp_n = 0; #1; chk("R7 lock on", hw_lock, 1);
    wren(); wrsr(8'h00, 1);
    chk("R7 wrsr rejected", status_byte, 8'h8E);
    wp_n = 1; #1; chk("R7 pin high releases", hw_lock, 0);
    wrsr(8'h00, 1); repeat (SR_CYCLES) @(negedge clk);
    chk("R7 accepted after release", status_byte, 8'h00);

    wp_n = 0; #1;
    set_status(8'h84);
    chk("R8 pin ignored with lock bit 0", status_byte, 8'h84);
    chk("R7 lock after bit set", hw_lock, 1);
    wp_n = 1; #1;

    for (int bp = 0; bp < 4; bp++) begin
      set_status(8'(bp << 2));
      wren(); #1;
      for (int pg = 0; pg < DEPTH >> PAGE_W; pg++) begin
        chk_addr = ADDR_W'(pg * (1 << PAGE_W) + (pg * 7) % (1 << PAGE_W)); #1;
        chk("R9 region", addr_locked, exp_lock(bp, chk_addr));
        chk("R10 permit", wr_permit, !exp_lock(bp, chk_addr));
      end
      arr_busy = 1; chk_addr = 0; #1;
      chk("R10 busy blocks permit", wr_permit, 0);
      arr_busy = 0; @(negedge clk);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule